// File: doc/BRIEF.md
# End-of-Task Interrupt Generator

This block turns task completions inside a coprocessor into interrupt pulses toward a host CPU. There is one interrupt line per task. By default a line pulses for a single cycle right after the coprocessor reports that the matching task has finished. The coprocessor gives this report as a strobe with a task index.

A per-task mode register can move any line into software mode. In software mode, completion of that task no longer raises the line. Instead, a running task fires the line by writing a 1 to the matching bit of a self-clearing trigger register. Any task may fire any line this way, including the line of a task that is not running.

Both registers sit behind two small register ports, one for the coprocessor and one for the host. Only the coprocessor port can change them. The host port can only read them.

Top module: `eot_irq_gen`

## Requirements
- R1: After a synchronous reset, every interrupt line is low, the mode register reads zero, and both read-data outputs are zero.
- R2: When a line's mode bit is 0 and `done_vld` is high with `done_idx` = k, line k is high for exactly the one cycle after that clock edge. All other lines stay low.
- R3: When mode bit k is 1, a completion of task k produces no pulse on line k.
- R4: A coprocessor write to address 1 (trigger register) pulses, in the next cycle, every line whose write-data bit is 1 and whose mode bit is 1. This is independent of which task completes or is running.
- R5: A trigger bit written for a line whose mode bit is 0 is discarded and leaves no pending event.
- R6: The mode register (address 0, bit k = line k, 1 = software mode) changes only on coprocessor-port writes. Host-port writes are ignored, even when they occur in the same cycle as a coprocessor write. Both ports read the register back.
- R7: Reads are registered: read data shows the addressed register one cycle after the address is presented. Address 1 always reads zero on both ports.
- R8: Writing a mode bit back to 0 restores completion-driven pulses on that line.
- R9: A completion and a trigger for the same line in the same cycle give a single one-cycle pulse.
- R10: A mode write takes effect from the following cycle. A completion in the same cycle as the write is judged against the previous mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_vld | input | 1 | Task completion strobe |
| done_idx | input | IDX_W | Index of the task that completed |
| cp_wr | input | 1 | Coprocessor-port write enable |
| cp_addr | input | 1 | Coprocessor-port address (0 mode, 1 trigger) |
| cp_wdata | input | N_TASKS | Coprocessor-port write data |
| cp_rdata | output | N_TASKS | Coprocessor-port read data, registered |
| hs_wr | input | 1 | Host-port write enable (ignored) |
| hs_addr | input | 1 | Host-port address |
| hs_wdata | input | N_TASKS | Host-port write data (ignored) |
| hs_rdata | output | N_TASKS | Host-port read data, registered |
| irq | output | N_TASKS | Registered one-cycle interrupt pulses, bit k for task k |

## Verification
The bench triggers a line that is in software mode while some other task completes, and triggers every line at once. A design that tied triggers to the completing task, or ignored the mode mask, would pulse the wrong set of lines. It writes triggers to lines in completion mode and watches the following cycles, which catches a trigger kept pending until the mode changes. It also writes the mode register from both ports in the same cycle and reads it back, which exposes a host path that leaks into the register. A completion that lands in the same cycle as a mode write must use the old mode, and a collision of completion and trigger must leave a single pulse. A design that pipelined the mode bit wrongly, or stretched the pulse, would show an extra or missing pulse there.

// File: rtl/eot_pkg.sv
package eot_pkg;
  // register addresses on both ports
  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_TRIG = 1'b1;
endpackage

// File: rtl/eot_task_decode.sv
module eot_task_decode #(
  parameter int N_TASKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic               done_vld,
  input  logic [IDX_W-1:0]   done_idx,
  output logic [N_TASKS-1:0] done_hot
);
  for (genvar j = 0; j < N_TASKS; j++) begin : g_dec
    assign done_hot[j] = done_vld && (done_idx == IDX_W'(j));
  end
endmodule

// File: rtl/eot_regfile.sv
module eot_regfile
  import eot_pkg::*;
#(
  parameter int N_TASKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cp_wr,
  input  logic               cp_addr,
  input  logic [N_TASKS-1:0] cp_wdata,
  input  logic               hs_wr,
  input  logic               hs_addr,
  input  logic [N_TASKS-1:0] hs_wdata,
  output logic [N_TASKS-1:0] cp_rdata,
  output logic [N_TASKS-1:0] hs_rdata,
  output logic [N_TASKS-1:0] mode_q,
  output logic [N_TASKS-1:0] trig_req
);
  // trigger register is a strobe only: nothing is stored
  assign trig_req = (cp_wr && cp_addr == ADDR_TRIG) ? cp_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      cp_rdata <= '0;
      hs_rdata <= '0;
    end else begin
      if (cp_wr && cp_addr == ADDR_MODE) mode_q <= cp_wdata;
      cp_rdata <= (cp_addr == ADDR_MODE) ? mode_q : '0;
      hs_rdata <= (hs_addr == ADDR_MODE) ? mode_q : '0;
    end
  end

  AST_HOST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hs_wr && hs_addr == ADDR_MODE && hs_wdata != mode_q && !cp_wr) |=> $stable(mode_q)); // R6
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cp_addr == ADDR_TRIG && hs_addr == ADDR_TRIG) |=> (cp_rdata == '0 && hs_rdata == '0)); // R7
endmodule

// File: rtl/eot_pulse_gen.sv
module eot_pulse_gen #(
  parameter int N_TASKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TASKS-1:0] done_hot,
  input  logic [N_TASKS-1:0] trig_req,
  input  logic [N_TASKS-1:0] mode_q,
  output logic [N_TASKS-1:0] irq
);
  for (genvar i = 0; i < N_TASKS; i++) begin : g_line
    logic fire;
    // mode selects the single source of the line, so a collision is one pulse
    assign fire = mode_q[i] ? trig_req[i] : done_hot[i];

    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= fire;
    end

    AST_COMPLETION_PULSE: assert property (@(posedge clk) disable iff (rst)
      (done_hot[i] && !mode_q[i]) |=> irq[i]); // R2
    AST_COMPLETION_MUTED: assert property (@(posedge clk) disable iff (rst)
      (done_hot[i] && mode_q[i] && !trig_req[i]) |=> !irq[i]); // R3
    AST_TRIGGER_PULSE: assert property (@(posedge clk) disable iff (rst)
      (trig_req[i] && mode_q[i]) |=> irq[i]); // R4
    AST_TRIGGER_DROPPED: assert property (@(posedge clk) disable iff (rst)
      (trig_req[i] && !mode_q[i] && !done_hot[i]) |=> !irq[i]); // R5
  end
endmodule

// File: rtl/eot_irq_gen.sv
module eot_irq_gen #(
  parameter  int N_TASKS = 8,
  localparam int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done_vld,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic               cp_wr,
  input  logic               cp_addr,
  input  logic [N_TASKS-1:0] cp_wdata,
  output logic [N_TASKS-1:0] cp_rdata,
  input  logic               hs_wr,
  input  logic               hs_addr,
  input  logic [N_TASKS-1:0] hs_wdata,
  output logic [N_TASKS-1:0] hs_rdata,
  output logic [N_TASKS-1:0] irq
);
  logic [N_TASKS-1:0] done_hot;
  logic [N_TASKS-1:0] mode_q;
  logic [N_TASKS-1:0] trig_req;

  eot_task_decode #(.N_TASKS(N_TASKS), .IDX_W(IDX_W)) u_dec (
    .done_vld (done_vld),
    .done_idx (done_idx),
    .done_hot (done_hot)
  );

  eot_regfile #(.N_TASKS(N_TASKS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cp_wr    (cp_wr),
    .cp_addr  (cp_addr),
    .cp_wdata (cp_wdata),
    .hs_wr    (hs_wr),
    .hs_addr  (hs_addr),
    .hs_wdata (hs_wdata),
    .cp_rdata (cp_rdata),
    .hs_rdata (hs_rdata),
    .mode_q   (mode_q),
    .trig_req (trig_req)
  );

  eot_pulse_gen #(.N_TASKS(N_TASKS)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .done_hot (done_hot),
    .trig_req (trig_req),
    .mode_q   (mode_q),
    .irq      (irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq == '0)); // R1
endmodule

// File: tb/eot_irq_gen_bench.sv
module eot_irq_gen_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_vld = 1'b0;
  logic [IW-1:0] done_idx = '0;
  logic cp_wr = 1'b0, cp_addr = 1'b0, hs_wr = 1'b0, hs_addr = 1'b0;
  logic [N-1:0] cp_wdata = '0, hs_wdata = '0;
  logic [N-1:0] cp_rdata, hs_rdata, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  eot_irq_gen #(.N_TASKS(N)) u_eot_irq_gen (
    .clk(clk), .rst(rst), .done_vld(done_vld), .done_idx(done_idx),
    .cp_wr(cp_wr), .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .hs_wr(hs_wr), .hs_addr(hs_addr), .hs_wdata(hs_wdata), .hs_rdata(hs_rdata),
    .irq(irq)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // present one cycle of stimulus, then return to idle just after the capturing edge
  task automatic step(logic dv, logic [IW-1:0] di, logic cw, logic ca, logic [N-1:0] cd,
                      logic hw, logic ha, logic [N-1:0] hd);
    done_vld = dv; done_idx = di;
    cp_wr = cw; cp_addr = ca; cp_wdata = cd;
    hs_wr = hw; hs_addr = ha; hs_wdata = hd;
    @(negedge clk);
    done_vld = 0; cp_wr = 0; hs_wr = 0; cp_wdata = '0; hs_wdata = '0;
  endtask

  task automatic done(logic [IW-1:0] k);
    step(1'b1, k, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic cp_write(logic a, logic [N-1:0] d);
    step(1'b0, '0, 1'b1, a, d, 1'b0, 1'b0, '0);
  endtask

  task automatic read_both(string req, logic a, logic [N-1:0] exp);
    cp_addr = a; hs_addr = a;
    @(negedge clk);
    chk({req, " cp read"}, cp_rdata, exp);
    chk({req, " host read"}, hs_rdata, exp);
    cp_addr = 0; hs_addr = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", irq, '0);
    read_both("R1 mode reg", 1'b0, '0);
  endtask

  task automatic t_completion;
    for (int k = 0; k < N; k++) begin
      done(IW'(k));
      chk("R2 completion pulse", irq, N'(1) << k);
      @(negedge clk);
      chk("R2 pulse one cycle", irq, '0);
    end
  endtask

  task automatic t_host_ignored;
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 8'hFF);
    read_both("R6 host write ignored", 1'b0, '0);
    done(3'd2);
    chk("R6 host write no mode effect", irq, 8'h04);
    // both ports write in one cycle: coprocessor value wins
    step(1'b0, '0, 1'b1, 1'b0, 8'h30, 1'b1, 1'b0, 8'hC3);
    read_both("R6 simultaneous write", 1'b0, 8'h30);
    cp_write(1'b0, 8'h00);
  endtask

  task automatic t_mode_suppress;
    cp_write(1'b0, 8'h0A);
    read_both("R6 mode readback", 1'b0, 8'h0A);
    done(3'd1);
    chk("R3 completion muted", irq, '0);
    @(negedge clk);
    chk("R3 no late pulse", irq, '0);
    done(3'd0);
    chk("R2 unaffected line", irq, 8'h01);
  endtask

  task automatic t_trigger;
    // task 5 completes while task 3's line is fired
    step(1'b1, 3'd5, 1'b1, 1'b1, 8'h08, 1'b0, 1'b0, '0);
    chk("R4 trigger other line", irq, 8'h28);
    @(negedge clk);
    chk("R4 pulse one cycle", irq, '0);
    cp_write(1'b1, 8'hFF);
    chk("R4 trigger masked by mode", irq, 8'h0A);
    cp_write(1'b1, 8'h04);
    chk("R5 trigger discarded", irq, '0);
    @(negedge clk);
    chk("R5 nothing pending", irq, '0);
    read_both("R7 trigger reads zero", 1'b1, '0);
  endtask

  task automatic t_collision;
    step(1'b1, 3'd3, 1'b1, 1'b1, 8'h08, 1'b0, 1'b0, '0);
    chk("R9 collision pulse", irq, 8'h08);
    @(negedge clk);
    chk("R9 single pulse", irq, '0);
    step(1'b1, 3'd0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, '0);
    chk("R9 collision completion mode", irq, 8'h01);
    @(negedge clk);
    chk("R9 single pulse completion mode", irq, '0);
  endtask

  task automatic t_restore;
    cp_write(1'b0, 8'h00);
    done(3'd1);
    chk("R8 completion restored", irq, 8'h02);
    @(negedge clk);
    // mode write and completion in the same cycle: old mode (0) applies
    step(1'b1, 3'd6, 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, '0);
    chk("R10 old mode in write cycle", irq, 8'h40);
    done(3'd6);
    chk("R10 new mode next cycle", irq, '0);
    cp_write(1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_completion();
    t_host_ignored();
    t_mode_suppress();
    t_trigger();
    t_collision();
    t_restore();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule